// File: doc/BRIEF.md
# Dual-Port RAM with Cross-Port Doorbell Interrupts

This block is a synchronous true dual-port RAM, one byte wide by default, with two identical ports called left and right. Either port can read or write any word on any clock edge. Each port has active-low select, write and output-enable strobes, an address, write data, registered read data, an active-low busy input and an active-low interrupt output.

The two highest words also act as doorbells between the ports. The top word belongs to the right port and the word below it belongs to the left port. When the left port writes the top word, the right interrupt goes low. It stays low until the right port reads that word. The next-to-top word works the same way in the other direction. Software on either side uses this to tell the other side that a message is waiting. The doorbell words still store and return data like every other word.

A port whose busy input is low still reads and writes the memory. While busy is low, that port's accesses cannot ring or acknowledge a doorbell. A synchronous active-low reset clears both doorbell flags and both read-data registers. The memory contents are not reset.

Top module: `dpdb_ram`

## Requirements
- R1: On a clock edge with `rst_n` low, both interrupt outputs are driven high and both read-data outputs are driven to zero.
- R2: A port writes when select and write-enable are both low. It reads when select is low, write-enable is high and output-enable is low. Read data appears on that port's `rdata` after the same edge and then holds until the port's next read. When select, write-enable and output-enable are all low, the access is a write only, and `rdata` holds.
- R3: A left write to address `2**AW-1` with `l_busy_n` high drives `r_irq_n` low after that edge.
- R4: A right read of address `2**AW-1` with `r_busy_n` high drives `r_irq_n` high after that edge.
- R5: A right write to address `2**AW-2` with `r_busy_n` high drives `l_irq_n` low after that edge.
- R6: A left read of address `2**AW-2` with `l_busy_n` high drives `l_irq_n` high after that edge.
- R7: A doorbell access made while the accessing port's busy input is low leaves both interrupt outputs unchanged. The memory access itself still takes place.
- R8: When one flag is rung and acknowledged on the same edge, the interrupt ends up low.
- R9: Some accesses leave both interrupt outputs unchanged: a port writing the word it receives on, a port reading the word it rings with, and any access below address `2**AW-2`. The doorbell words still store written data and return it on a read.
- R10: When both ports write the same address on the same edge, the left data is stored. A read of an address that the other port writes on the same edge returns the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| l_cs_n | input | 1 | Left select, active low |
| l_we_n | input | 1 | Left write enable, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | AW | Left word address |
| l_wdata | input | DW | Left write data |
| l_busy_n | input | 1 | Left busy, active low; blocks left doorbell effects |
| l_rdata | output | DW | Left registered read data |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_cs_n | input | 1 | Right select, active low |
| r_we_n | input | 1 | Right write enable, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | AW | Right word address |
| r_wdata | input | DW | Right write data |
| r_busy_n | input | 1 | Right busy, active low; blocks right doorbell effects |
| r_rdata | output | DW | Right registered read data |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
Every result of this block is due exactly one clock edge after the stimulus that causes it. Both read data and the interrupt levels change on the edge where the access is sampled, and nothing takes longer. The bench applies each access half a cycle before an edge. At the same time it pushes the outputs it expects after that edge, computed from its own memory and flag model. The monitor pops and compares each entry a short time after the following rising edge, so every comparison lands in the cycle where the result is due.

// File: rtl/dpdb_pkg.sv
// Shared types for the dual-port doorbell RAM.
// Assumes: side index 0 is the left port, 1 is the right port.
package dpdb_pkg;

    localparam int SIDES = 2;
    localparam int LEFT  = 0;
    localparam int RIGHT = 1;

    // Decoded command of one port for one cycle.
    typedef struct packed {
        logic wr;    // write to the array this cycle
        logic rd;    // read from the array this cycle
        logic ring;  // effective write to the doorbell word of the far side
        logic ack;   // effective read of this port's own doorbell word
    } port_cmd_t;

    // Returns the opposite side index.
    function automatic int far_side(input int side);
        return (side == LEFT) ? RIGHT : LEFT;
    endfunction

endpackage

// File: rtl/dpdb_port_decode.sv
// Decodes the raw active-low strobes of one port into a command.
// Assumes: write wins over read when both strobes are low.
// RX_ADDR is the word this port receives doorbells on.
// TX_ADDR is the word it writes to ring the far side.
// A low busy input blocks only the doorbell side effects, never storage.
module dpdb_port_decode
    import dpdb_pkg::*;
#(
    parameter int AW = 10,
    parameter logic [AW-1:0] RX_ADDR = '1,
    parameter logic [AW-1:0] TX_ADDR = '0
) (
    input  logic          cs_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic          busy_n,
    output port_cmd_t     cmd
);

    logic sel;
    logic hit_rx;
    logic hit_tx;

    // Build the command from the strobes, the address match and busy.
    always_comb begin
        sel    = ~cs_n;
        hit_rx = (addr == RX_ADDR);
        hit_tx = (addr == TX_ADDR);
        cmd.wr   = sel & ~we_n;
        cmd.rd   = sel & we_n & ~oe_n;
        cmd.ring = cmd.wr & hit_tx & busy_n;
        cmd.ack  = cmd.rd & hit_rx & busy_n;
    end

endmodule

// File: rtl/dpdb_flag.sv
// One doorbell flag driving an active-low interrupt.
// Assumes: a set wins over a clear on the same edge, so no ring is lost.
// The reset is synchronous and active low, and leaves the interrupt inactive.
module dpdb_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic irq_n
);

    // Update the pending state; set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_n <= 1'b1;
        end else if (set) begin
            irq_n <= 1'b0;
        end else if (clr) begin
            irq_n <= 1'b1;
        end
    end

endmodule

// File: rtl/dpdb_store.sv
// Word storage with one write and one read path on each of the two sides.
// Assumes: read-before-write. A read returns the contents from before this edge.
// When both sides write one word on one edge, the left side's data is kept.
// Read registers are zeroed by the synchronous reset. The array is not reset.
module dpdb_store
    import dpdb_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr   [SIDES],
    input  logic          rd   [SIDES],
    input  logic [AW-1:0] addr [SIDES],
    input  logic [DW-1:0] wdata[SIDES],
    output logic [DW-1:0] rdata[SIDES]
);

    logic [DW-1:0] mem [DEPTH];

    // Array writes; the left write is applied last so it wins a collision.
    always_ff @(posedge clk) begin
        if (wr[RIGHT]) begin
            mem[addr[RIGHT]] <= wdata[RIGHT];
        end
        if (wr[LEFT]) begin
            mem[addr[LEFT]] <= wdata[LEFT];
        end
    end

    genvar s;
    generate
        for (s = 0; s < SIDES; s++) begin : g_rd
            // Registered read data for one side; holds between reads.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rdata[s] <= '0;
                end else if (rd[s]) begin
                    rdata[s] <= mem[addr[s]];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/dpdb_ram.sv
// Top of the dual-port RAM with cross-port doorbell interrupts.
// The top word is the right port's doorbell and the word below it is the left port's.
// A write by the far port rings a doorbell, and a read by the owner acknowledges it.
// Assumes: one clock for both ports and a synchronous active-low reset.
module dpdb_ram
    import dpdb_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 8,
    localparam logic [AW-1:0] TOP_ADDR = '1,
    localparam logic [AW-1:0] NXT_ADDR = TOP_ADDR - 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          l_cs_n,
    input  logic          l_we_n,
    input  logic          l_oe_n,
    input  logic [AW-1:0] l_addr,
    input  logic [DW-1:0] l_wdata,
    input  logic          l_busy_n,
    output logic [DW-1:0] l_rdata,
    output logic          l_irq_n,
    input  logic          r_cs_n,
    input  logic          r_we_n,
    input  logic          r_oe_n,
    input  logic [AW-1:0] r_addr,
    input  logic [DW-1:0] r_wdata,
    input  logic          r_busy_n,
    output logic [DW-1:0] r_rdata,
    output logic          r_irq_n
);

    logic          cs_n  [SIDES];
    logic          we_n  [SIDES];
    logic          oe_n  [SIDES];
    logic          busy_n[SIDES];
    logic [AW-1:0] addr  [SIDES];
    logic [DW-1:0] wdata [SIDES];
    logic [DW-1:0] rdata [SIDES];
    logic          irq_n [SIDES];
    port_cmd_t     cmd   [SIDES];
    logic          wr    [SIDES];
    logic          rd    [SIDES];

    // Gather the named ports into side-indexed arrays.
    always_comb begin
        cs_n[LEFT]   = l_cs_n;   cs_n[RIGHT]   = r_cs_n;
        we_n[LEFT]   = l_we_n;   we_n[RIGHT]   = r_we_n;
        oe_n[LEFT]   = l_oe_n;   oe_n[RIGHT]   = r_oe_n;
        busy_n[LEFT] = l_busy_n; busy_n[RIGHT] = r_busy_n;
        addr[LEFT]   = l_addr;   addr[RIGHT]   = r_addr;
        wdata[LEFT]  = l_wdata;  wdata[RIGHT]  = r_wdata;
    end

    genvar s;
    generate
        for (s = 0; s < SIDES; s++) begin : g_side
            localparam logic [AW-1:0] RX = (s == RIGHT) ? TOP_ADDR : NXT_ADDR;
            localparam logic [AW-1:0] TX = (s == RIGHT) ? NXT_ADDR : TOP_ADDR;

            dpdb_port_decode #(
                .AW      (AW),
                .RX_ADDR (RX),
                .TX_ADDR (TX)
            ) u_dec (
                .cs_n   (cs_n[s]),
                .we_n   (we_n[s]),
                .oe_n   (oe_n[s]),
                .addr   (addr[s]),
                .busy_n (busy_n[s]),
                .cmd    (cmd[s])
            );

            // The interrupt toward side s is rung by the far side and acknowledged by s.
            dpdb_flag u_flag (
                .clk   (clk),
                .rst_n (rst_n),
                .set   (cmd[far_side(s)].ring),
                .clr   (cmd[s].ack),
                .irq_n (irq_n[s])
            );

            // Split out the storage strobes for the array.
            always_comb begin
                wr[s] = cmd[s].wr;
                rd[s] = cmd[s].rd;
            end
        end
    endgenerate

    dpdb_store #(
        .AW (AW),
        .DW (DW)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr),
        .rd    (rd),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata)
    );

    // Drive the named outputs from the side-indexed results.
    always_comb begin
        l_rdata = rdata[LEFT];
        r_rdata = rdata[RIGHT];
        l_irq_n = irq_n[LEFT];
        r_irq_n = irq_n[RIGHT];
    end

endmodule

// File: rtl/dpdb_ram_checker.sv
// Protocol checker for dpdb_ram, attached by bind. It watches ports only.
// Assumes: the same address map as the top (doorbells at the top two words).
module dpdb_ram_checker #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          l_cs_n,
    input logic          l_we_n,
    input logic          l_oe_n,
    input logic [AW-1:0] l_addr,
    input logic          l_busy_n,
    input logic [DW-1:0] l_rdata,
    input logic          l_irq_n,
    input logic          r_cs_n,
    input logic          r_we_n,
    input logic          r_oe_n,
    input logic [AW-1:0] r_addr,
    input logic          r_busy_n,
    input logic [DW-1:0] r_rdata,
    input logic          r_irq_n
);

    localparam logic [AW-1:0] TOP = '1;
    localparam logic [AW-1:0] NXT = TOP - 1'b1;

    logic l_wr, l_rd, r_wr, r_rd;
    logic ring_r, ack_r, ring_l, ack_l;
    logic rst_d, armed;

    // Port-level view of what each side does this cycle.
    always_comb begin
        l_wr   = !l_cs_n && !l_we_n;
        l_rd   = !l_cs_n && l_we_n && !l_oe_n;
        r_wr   = !r_cs_n && !r_we_n;
        r_rd   = !r_cs_n && r_we_n && !r_oe_n;
        ring_r = l_wr && (l_addr == TOP) && l_busy_n;
        ack_r  = r_rd && (r_addr == TOP) && r_busy_n;
        ring_l = r_wr && (r_addr == NXT) && r_busy_n;
        ack_l  = l_rd && (l_addr == NXT) && l_busy_n;
    end

    // Remember the reset level of the previous edge.
    always_ff @(posedge clk) begin
        rst_d <= rst_n;
        armed <= 1'b1;
    end

    // Check that a reset edge leaves both outputs idle.
    always_ff @(posedge clk) begin
        if (armed && !rst_d) begin
            assert_reset_idle_R1: assert (l_irq_n && r_irq_n && l_rdata == '0 && r_rdata == '0)
                else $error("reset did not idle outputs");
        end
    end

    assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_rd && !r_rd && rst_d) |=> ($stable(l_rdata) && $stable(r_rdata)));

    assert_ring_right_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ring_r |=> !r_irq_n);

    assert_ack_right_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_r && !ring_r) |=> r_irq_n);

    assert_ring_left_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ring_l |=> !l_irq_n);

    assert_ack_left_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_l && !ring_l) |=> l_irq_n);

    assert_quiet_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ring_r && !ack_r && !ring_l && !ack_l && rst_d)
            |=> ($stable(r_irq_n) && $stable(l_irq_n)));

endmodule

bind dpdb_ram dpdb_ram_checker #(.AW(AW), .DW(DW)) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .l_cs_n   (l_cs_n),
    .l_we_n   (l_we_n),
    .l_oe_n   (l_oe_n),
    .l_addr   (l_addr),
    .l_busy_n (l_busy_n),
    .l_rdata  (l_rdata),
    .l_irq_n  (l_irq_n),
    .r_cs_n   (r_cs_n),
    .r_we_n   (r_we_n),
    .r_oe_n   (r_oe_n),
    .r_addr   (r_addr),
    .r_busy_n (r_busy_n),
    .r_rdata  (r_rdata),
    .r_irq_n  (r_irq_n)
);

// File: tb/dpdb_ram_tb.sv
// Scoreboard bench for dpdb_ram.
// The driver applies one cycle of stimulus and queues the expected outputs.
// The monitor compares them just after the following rising edge.
module dpdb_ram_tb;

    localparam int AW    = 10;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;
    localparam logic [AW-1:0] TOP = '1;
    localparam logic [AW-1:0] NXT = TOP - 1'b1;

    typedef struct {
        logic [DW-1:0] l_rd;
        logic [DW-1:0] r_rd;
        logic          l_irq;
        logic          r_irq;
        string         tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n;
    logic l_cs_n, l_we_n, l_oe_n, l_busy_n;
    logic r_cs_n, r_we_n, r_oe_n, r_busy_n;
    logic [AW-1:0] l_addr, r_addr;
    logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
    logic l_irq_n, r_irq_n;

    int compared = 0;
    int mismatched = 0;
    exp_t sb[$];

    logic [DW-1:0] mdl_mem [DEPTH];
    logic [DW-1:0] mdl_lrd, mdl_rrd;
    logic          mdl_lirq, mdl_rirq;

    always #2.5 clk = ~clk;

    dpdb_ram #(.AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .l_cs_n(l_cs_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_addr(l_addr),
        .l_wdata(l_wdata), .l_busy_n(l_busy_n), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
        .r_cs_n(r_cs_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_addr(r_addr),
        .r_wdata(r_wdata), .r_busy_n(r_busy_n), .r_rdata(r_rdata), .r_irq_n(r_irq_n)
    );

    // Compare one field and count it.
    task automatic cmp(input string tag, input string what, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Monitor: after each rising edge pop one expectation and compare.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                cmp(e.tag, "l_rdata", l_rdata, e.l_rd);
                cmp(e.tag, "r_rdata", r_rdata, e.r_rd);
                cmp(e.tag, "l_irq_n", {{(DW-1){1'b0}}, l_irq_n}, {{(DW-1){1'b0}}, e.l_irq});
                cmp(e.tag, "r_irq_n", {{(DW-1){1'b0}}, r_irq_n}, {{(DW-1){1'b0}}, e.r_irq});
            end
        end
    end

    // Driver: one cycle of stimulus. Updates the model and queues the expected outputs.
    // Port ops: 0 idle, 1 write, 2 read, 3 all strobes low (write only).
    task automatic step(input logic rst, input int lop, input logic [AW-1:0] la,
                        input logic [DW-1:0] ld, input logic lb,
                        input int rop, input logic [AW-1:0] ra,
                        input logic [DW-1:0] rd, input logic rb, input string tag);
        exp_t e;
        logic lw, lr, rw, rr, set_r, clr_r, set_l, clr_l;
        @(negedge clk);
        rst_n    = rst;
        l_cs_n   = (lop == 0);
        l_we_n   = !(lop == 1 || lop == 3);
        l_oe_n   = !(lop == 2 || lop == 3);
        l_addr   = la; l_wdata = ld; l_busy_n = lb;
        r_cs_n   = (rop == 0);
        r_we_n   = !(rop == 1 || rop == 3);
        r_oe_n   = !(rop == 2 || rop == 3);
        r_addr   = ra; r_wdata = rd; r_busy_n = rb;
        lw = (lop == 1 || lop == 3);
        lr = (lop == 2);
        rw = (rop == 1 || rop == 3);
        rr = (rop == 2);
        if (!rst) begin
            mdl_lrd = '0; mdl_rrd = '0; mdl_lirq = 1'b1; mdl_rirq = 1'b1;
        end else begin
            set_r = lw && la == TOP && lb;
            clr_r = rr && ra == TOP && rb;
            set_l = rw && ra == NXT && rb;
            clr_l = lr && la == NXT && lb;
            if (lr) mdl_lrd = mdl_mem[la];
            if (rr) mdl_rrd = mdl_mem[ra];
            if (set_r) mdl_rirq = 1'b0; else if (clr_r) mdl_rirq = 1'b1;
            if (set_l) mdl_lirq = 1'b0; else if (clr_l) mdl_lirq = 1'b1;
        end
        if (rw) mdl_mem[ra] = rd;
        if (lw) mdl_mem[la] = ld;
        e.l_rd = mdl_lrd; e.r_rd = mdl_rrd;
        e.l_irq = mdl_lirq; e.r_irq = mdl_rirq; e.tag = tag;
        sb.push_back(e);
    endtask

    // Main sequence of directed cases, one requirement tag each.
    initial begin
        step(1'b0, 0, '0, '0, 1'b1, 0, '0, '0, 1'b1, "R1 reset");
        step(1'b0, 1, 10'h5, 8'h11, 1'b1, 0, '0, '0, 1'b1, "R1 reset");
        step(1'b1, 0, '0, '0, 1'b1, 0, '0, '0, 1'b1, "R1 idle after reset");
        // R2 plain storage in both directions
        step(1'b1, 1, 10'h012, 8'hA5, 1'b1, 1, 10'h034, 8'h3C, 1'b1, "R2 write");
        step(1'b1, 2, 10'h034, '0, 1'b1, 2, 10'h012, '0, 1'b1, "R2 cross read");
        step(1'b1, 0, '0, '0, 1'b1, 0, '0, '0, 1'b1, "R2 hold");
        step(1'b1, 3, 10'h012, 8'h77, 1'b1, 0, '0, '0, 1'b1, "R2 write wins");
        step(1'b1, 2, 10'h012, '0, 1'b1, 0, '0, '0, 1'b1, "R2 readback");
        // R3 and R4 right doorbell
        step(1'b1, 1, TOP, 8'hC1, 1'b1, 0, '0, '0, 1'b1, "R3 ring right");
        step(1'b1, 0, '0, '0, 1'b1, 0, '0, '0, 1'b1, "R3 stays low");
        step(1'b1, 0, '0, '0, 1'b1, 2, TOP, '0, 1'b1, "R4 ack right");
        // R5 and R6 left doorbell
        step(1'b1, 0, '0, '0, 1'b1, 1, NXT, 8'hD2, 1'b1, "R5 ring left");
        step(1'b1, 2, NXT, '0, 1'b1, 0, '0, '0, 1'b1, "R6 ack left");
        // R7 busy blocks ring and ack, keeps storage
        step(1'b1, 1, TOP, 8'hE3, 1'b0, 1, NXT, 8'hE4, 1'b0, "R7 busy ring");
        step(1'b1, 2, NXT, '0, 1'b1, 2, TOP, '0, 1'b1, "R7 data stored");
        step(1'b1, 1, TOP, 8'hE5, 1'b1, 1, NXT, 8'hE6, 1'b1, "R7 ring both");
        step(1'b1, 2, NXT, '0, 1'b0, 2, TOP, '0, 1'b0, "R7 busy ack");
        // R8 ring and ack on the same edge
        step(1'b1, 1, TOP, 8'hF0, 1'b1, 2, TOP, '0, 1'b1, "R8 set wins right");
        step(1'b1, 2, NXT, '0, 1'b1, 1, NXT, 8'hF1, 1'b1, "R8 set wins left");
        step(1'b1, 0, '0, '0, 1'b1, 2, TOP, '0, 1'b1, "R8 clear right");
        step(1'b1, 2, NXT, '0, 1'b1, 0, '0, '0, 1'b1, "R8 clear left");
        // R9 wrong-direction accesses and low addresses
        step(1'b1, 1, NXT, 8'h5A, 1'b1, 1, TOP, 8'hA5, 1'b1, "R9 own word write");
        step(1'b1, 2, TOP, '0, 1'b1, 2, NXT, '0, 1'b1, "R9 far word read");
        step(1'b1, 1, NXT - 1'b1, 8'h66, 1'b1, 1, 10'h0, 8'h99, 1'b1, "R9 low address");
        step(1'b1, 2, NXT - 1'b1, '0, 1'b1, 2, 10'h0, '0, 1'b1, "R9 low readback");
        // R10 collisions
        step(1'b1, 1, 10'h100, 8'h01, 1'b1, 1, 10'h100, 8'h02, 1'b1, "R10 dual write");
        step(1'b1, 2, 10'h100, '0, 1'b1, 1, 10'h100, 8'h03, 1'b1, "R10 old on collide");
        step(1'b1, 2, 10'h100, '0, 1'b1, 2, 10'h100, '0, 1'b1, "R10 new value");
        // R1 reset with flags pending
        step(1'b1, 1, TOP, 8'h10, 1'b1, 1, NXT, 8'h20, 1'b1, "R1 pre-reset ring");
        step(1'b0, 0, '0, '0, 1'b1, 0, '0, '0, 1'b1, "R1 reset clears flags");
        step(1'b1, 0, '0, '0, 1'b1, 0, '0, '0, 1'b1, "R1 idle");
        @(negedge clk);
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (5000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog all-requirements actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule